// File: doc/BRIEF.md
# Contact Card Session Sequencer

This block sits between a host controller and the analog front end of a contact smart card socket. It powers the card contacts up and down in a fixed order. An active-low supply command from the host starts a session, provided the card is seated, both supply-good flags are true and the host data line is not held low. The block then switches on the card supply, then the programming supply at its normal level together with the data-line switch, and finally the card clock and card reset path. Each step is separated by a fixed number of internal timer ticks. When the host releases the command, the same step counter runs backward and the contacts are shut down in the reverse order.

While a session is open, three active-low level selects move the programming supply from its normal level to one of three higher levels. This is write mode; read mode is the state with no select held. A fault ends the session with an automatic shutdown and a latched active-low interrupt. The fault sources are an overcurrent on either supply, overtemperature, loss of either supply-good flag, or card removal. The interrupt is released only after the host has raised the supply command again. Step timing comes from a tick prescaler on the system clock, so every gap is a parameter counted in ticks.

Top module: `card_session_seq`

## Requirements
- R1: After reset the block is in idle and every card enable, `card_rst` and `vpp_level` are 0, while `fault_irq_n` is 1. The `mode` output encodes idle=0, activation=1, read=2, write=3, deactivation=4 and fault=5.
- R2: `card_det` is 1 exactly when `pres_n` is 0 and `pres_h` is 1, at all times.
- R3: A session starts from idle only while all of the following hold: `cmd_vcc_n` is 0, `host_io` is 1, both supply-good flags are 1 and the card is present. If any of them is missing, the block stays in idle with all enables off.
- R4: Activation order is fixed. `card_vcc_en` rises one clock after the start condition. `card_vpp_en` and `card_io_en` rise together GAP_VCC_IO ticks later. `card_clk_en` rises GAP_IO_CLK ticks after that, and the mode becomes read in that same cycle. Each gap is GAP×TICK_DIV+1 system clocks.
- R5: `card_rst` follows `rst_req` only while `card_clk_en` is 1, and is 0 otherwise.
- R6: In read or write mode, any low bit of `prog_sel_n` selects write mode and the highest low bit wins. `vpp_level` is 1 for bit 0, 2 for bit 1, 3 for bit 2, and 0 (normal level) when no bit is low. With all bits high the mode is read. Both `vpp_level` and `mode` update one clock after the select changes.
- R7: Outside read and write mode, `prog_sel_n` has no effect: `vpp_level` stays 0 and the mode does not change.
- R8: When `cmd_vcc_n` rises during a session, the clock and reset are cut one clock later. `card_vpp_en` and `card_io_en` fall GAP_DOWN ticks after that, and `card_vcc_en` falls a further GAP_DOWN ticks later. The mode returns to idle one tick after that, and `vpp_level` is 0 throughout the shutdown.
- R9: In activation, read or write mode, any one of the following drives `fault_irq_n` low and starts the shutdown of R8 one clock later: `vcc_ocp` high, `vpp_ocp` high, `over_temp` high, either supply-good flag low, or the card no longer present.
- R10: After a fault shutdown the mode holds at fault, with `fault_irq_n` low, for as long as `cmd_vcc_n` stays 0. One clock after `cmd_vcc_n` is 1, the mode is idle and `fault_irq_n` is 1.
- R11: At all times, `card_vpp_en` implies `card_vcc_en`, and `card_clk_en` implies both `card_io_en` and `card_vpp_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vcc_n | input | 1 | Host supply command, active low |
| host_io | input | 1 | Level of the host-side data line |
| pres_n | input | 1 | Presence switch, active low |
| pres_h | input | 1 | Presence switch, active high |
| vcc_ocp | input | 1 | Card supply overcurrent flag |
| vpp_ocp | input | 1 | Programming supply overcurrent flag |
| over_temp | input | 1 | Overtemperature flag |
| host_sup_ok | input | 1 | Host supply good |
| main_sup_ok | input | 1 | Main supply good |
| prog_sel_n | input | N_LEVELS | Programming level selects, active low, higher index is higher level |
| rst_req | input | 1 | Card reset request from the host |
| card_vcc_en | output | 1 | Card supply enable |
| card_vpp_en | output | 1 | Programming supply enable |
| card_io_en | output | 1 | Data-line switch enable |
| card_clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Gated card reset |
| vpp_level | output | LVL_W | Programming level code, 0 is the normal level |
| card_det | output | 1 | Card present indication |
| fault_irq_n | output | 1 | Latched fault interrupt, active low |
| mode | output | 3 | Current operating mode |

## Verification
A fault flag and the host releasing the supply command can arrive in the same cycle, and both then lead to the same shutdown. The bench raises an overcurrent flag on the same clock edge as `cmd_vcc_n` and checks three things: the interrupt must still latch, the shutdown must run its full length, and the fault mode must last exactly one cycle before idle, because the command is already high. A second overlap, a level select changing while the session ends, is provoked by releasing the command during write mode with a select still low. In that case `vpp_level` is expected to drop to 0 on the first shutdown cycle.

// File: rtl/cs_pkg.sv
package cs_pkg;

   typedef enum logic [2:0] {
      M_IDLE  = 3'd0,
      M_ACT   = 3'd1,
      M_READ  = 3'd2,
      M_WRITE = 3'd3,
      M_DEACT = 3'd4,
      M_FAULT = 3'd5
   } cs_mode_e;

   // step counter positions, forward order is the power-up order
   localparam logic [1:0] STEP_OFF    = 2'd0;
   localparam logic [1:0] STEP_SUPPLY = 2'd1;
   localparam logic [1:0] STEP_LINES  = 2'd2;
   localparam logic [1:0] STEP_CLOCK  = 2'd3;

   typedef struct packed {
      logic vcc;
      logic vpp;
      logic io;
      logic clk;
   } cs_enables_t;

endpackage

// File: rtl/cs_tick_timer.sv
module cs_tick_timer #(
   parameter int TICK_DIV = 10,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] ticks
);

   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      assert (TICK_DIV >= 1) else $fatal(1, "TICK_DIV must be at least 1");
      assert (CNT_W >= 2) else $fatal(1, "CNT_W must be at least 2");
   end

   logic tick;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = !clr;
      end else begin : g_div
         logic [PRE_W-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre <= '0;
            end else if (clr) begin
               pre <= '0;
            end else if (pre == PRE_W'(TICK_DIV - 1)) begin
               pre <= '0;
            end else begin
               pre <= pre + 1'b1;
            end
         end
         assign tick = (pre == PRE_W'(TICK_DIV - 1)) && !clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks <= '0;
      end else if (clr) begin
         ticks <= '0;
      end else if (tick && (ticks != CNT_MAX)) begin
         ticks <= ticks + 1'b1;
      end
   end

endmodule

// File: rtl/cs_fault_mon.sv
module cs_fault_mon (
   input  logic pres_n,
   input  logic pres_h,
   input  logic vcc_ocp,
   input  logic vpp_ocp,
   input  logic over_temp,
   input  logic host_sup_ok,
   input  logic main_sup_ok,
   output logic present,
   output logic supplies_ok,
   output logic hard_fault
);

   always_comb begin
      present     = !pres_n && pres_h;
      supplies_ok = host_sup_ok && main_sup_ok;
      hard_fault  = vcc_ocp || vpp_ocp || over_temp || !supplies_ok;
   end

endmodule

// File: rtl/cs_level_sel.sv
module cs_level_sel #(
   parameter int N_LEVELS = 3,
   parameter int LVL_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold_en,
   input  logic [N_LEVELS-1:0] sel_n,
   output logic                sel_any,
   output logic [LVL_W-1:0]    level_q
);

   initial begin
      assert (N_LEVELS >= 1) else $fatal(1, "N_LEVELS must be at least 1");
      assert ((1 << LVL_W) > N_LEVELS) else $fatal(1, "LVL_W too narrow");
   end

   logic [LVL_W-1:0] level_c;

   // scan upward so the highest active select overwrites lower ones
   always_comb begin
      level_c = '0;
      for (int i = 0; i < N_LEVELS; i++) begin
         if (!sel_n[i]) level_c = LVL_W'(i + 1);
      end
      sel_any = (sel_n != '1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (hold_en) begin
         level_q <= level_c;
      end else begin
         level_q <= '0;
      end
   end

endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
   import cs_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int GAP_VCC_IO = 16,
   parameter int GAP_IO_CLK = 64,
   parameter int GAP_DOWN   = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_vcc_n,
   input  logic             host_io,
   input  logic             present,
   input  logic             supplies_ok,
   input  logic             hard_fault,
   input  logic             sel_any,
   input  logic [CNT_W-1:0] ticks,
   output cs_mode_e         mode_q,
   output cs_mode_e         mode_nx,
   output logic [1:0]       step_q,
   output logic             fault_q,
   output logic             timer_clr
);

   initial begin
      assert (GAP_VCC_IO >= 1 && GAP_IO_CLK >= 1 && GAP_DOWN >= 1)
         else $fatal(1, "step gaps must be at least one tick");
      assert ((1 << CNT_W) > GAP_IO_CLK && (1 << CNT_W) > GAP_DOWN
              && (1 << CNT_W) > GAP_VCC_IO)
         else $fatal(1, "CNT_W too narrow for the gaps");
   end

   logic [1:0]       step_nx;
   logic             fault_nx;
   logic [CNT_W-1:0] target;
   logic             gap_done;
   logic             abort;

   always_comb begin
      target = '0;
      unique case (mode_q)
         M_ACT:   target = (step_q == STEP_SUPPLY) ? CNT_W'(GAP_VCC_IO)
                                                   : CNT_W'(GAP_IO_CLK);
         M_DEACT: target = (step_q == STEP_OFF) ? CNT_W'(1)
                                                : CNT_W'(GAP_DOWN);
         default: target = '0;
      endcase
      gap_done = (ticks >= target);
      abort    = hard_fault || !present;
   end

   always_comb begin
      mode_nx  = mode_q;
      step_nx  = step_q;
      fault_nx = fault_q;
      unique case (mode_q)
         M_IDLE: begin
            if (!cmd_vcc_n && host_io && supplies_ok && present) begin
               mode_nx = M_ACT;
               step_nx = STEP_SUPPLY;
            end
         end
         M_ACT, M_READ, M_WRITE: begin
            if (abort || cmd_vcc_n) begin
               mode_nx  = M_DEACT;
               step_nx  = (step_q == STEP_CLOCK) ? STEP_LINES : step_q;
               fault_nx = fault_q || abort;
            end else if (mode_q == M_ACT) begin
               if (gap_done) begin
                  if (step_q == STEP_SUPPLY) begin
                     step_nx = STEP_LINES;
                  end else begin
                     step_nx = STEP_CLOCK;
                     mode_nx = M_READ;
                  end
               end
            end else if (mode_q == M_READ) begin
               if (sel_any) mode_nx = M_WRITE;
            end else begin
               if (!sel_any) mode_nx = M_READ;
            end
         end
         M_DEACT: begin
            if (gap_done) begin
               if (step_q != STEP_OFF) begin
                  step_nx = step_q - 1'b1;
               end else begin
                  mode_nx = fault_q ? M_FAULT : M_IDLE;
               end
            end
         end
         M_FAULT: begin
            if (cmd_vcc_n) begin
               mode_nx  = M_IDLE;
               fault_nx = 1'b0;
            end
         end
         default: begin
            mode_nx = M_IDLE;
            step_nx = STEP_OFF;
         end
      endcase
      timer_clr = (step_nx != step_q) || (mode_nx != mode_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_IDLE;
         step_q  <= STEP_OFF;
         fault_q <= 1'b0;
      end else begin
         mode_q  <= mode_nx;
         step_q  <= step_nx;
         fault_q <= fault_nx;
      end
   end

endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
   import cs_pkg::*;
#(
   parameter int TICK_DIV   = 10,
   parameter int GAP_VCC_IO = 16,
   parameter int GAP_IO_CLK = 64,
   parameter int GAP_DOWN   = 48,
   parameter int N_LEVELS   = 3,
   localparam int LVL_W     = $clog2(N_LEVELS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_vcc_n,
   input  logic                host_io,
   input  logic                pres_n,
   input  logic                pres_h,
   input  logic                vcc_ocp,
   input  logic                vpp_ocp,
   input  logic                over_temp,
   input  logic                host_sup_ok,
   input  logic                main_sup_ok,
   input  logic [N_LEVELS-1:0] prog_sel_n,
   input  logic                rst_req,
   output logic                card_vcc_en,
   output logic                card_vpp_en,
   output logic                card_io_en,
   output logic                card_clk_en,
   output logic                card_rst,
   output logic [LVL_W-1:0]    vpp_level,
   output logic                card_det,
   output logic                fault_irq_n,
   output logic [2:0]          mode
);

   localparam int GAP_MAX_AB = (GAP_VCC_IO > GAP_IO_CLK) ? GAP_VCC_IO : GAP_IO_CLK;
   localparam int GAP_MAX    = (GAP_MAX_AB > GAP_DOWN) ? GAP_MAX_AB : GAP_DOWN;
   localparam int CNT_W      = $clog2(GAP_MAX + 1) + 1;

   logic             present;
   logic             supplies_ok;
   logic             hard_fault;
   logic             sel_any;
   logic [CNT_W-1:0] ticks;
   logic             timer_clr;
   cs_mode_e         mode_q;
   cs_mode_e         mode_nx;
   logic [1:0]       step_q;
   logic             fault_q;
   cs_enables_t      en;

   cs_fault_mon i_mon (
      .pres_n      (pres_n),
      .pres_h      (pres_h),
      .vcc_ocp     (vcc_ocp),
      .vpp_ocp     (vpp_ocp),
      .over_temp   (over_temp),
      .host_sup_ok (host_sup_ok),
      .main_sup_ok (main_sup_ok),
      .present     (present),
      .supplies_ok (supplies_ok),
      .hard_fault  (hard_fault)
   );

   cs_tick_timer #(
      .TICK_DIV (TICK_DIV),
      .CNT_W    (CNT_W)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (timer_clr),
      .ticks (ticks)
   );

   cs_seq_fsm #(
      .CNT_W      (CNT_W),
      .GAP_VCC_IO (GAP_VCC_IO),
      .GAP_IO_CLK (GAP_IO_CLK),
      .GAP_DOWN   (GAP_DOWN)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_vcc_n   (cmd_vcc_n),
      .host_io     (host_io),
      .present     (present),
      .supplies_ok (supplies_ok),
      .hard_fault  (hard_fault),
      .sel_any     (sel_any),
      .ticks       (ticks),
      .mode_q      (mode_q),
      .mode_nx     (mode_nx),
      .step_q      (step_q),
      .fault_q     (fault_q),
      .timer_clr   (timer_clr)
   );

   cs_level_sel #(
      .N_LEVELS (N_LEVELS),
      .LVL_W    (LVL_W)
   ) i_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_en (mode_nx == M_WRITE),
      .sel_n   (prog_sel_n),
      .sel_any (sel_any),
      .level_q (vpp_level)
   );

   always_comb begin
      en.vcc = (step_q >= STEP_SUPPLY);
      en.vpp = (step_q >= STEP_LINES);
      en.io  = (step_q >= STEP_LINES);
      en.clk = (step_q == STEP_CLOCK);
   end

   assign card_vcc_en = en.vcc;
   assign card_vpp_en = en.vpp;
   assign card_io_en  = en.io;
   assign card_clk_en = en.clk;
   assign card_rst    = en.clk && rst_req;
   assign card_det    = present;
   assign fault_irq_n = !fault_q;
   assign mode        = mode_q;

endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk
   import cs_pkg::*;
#(
   parameter int LVL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_vcc_n,
   input logic             card_vcc_en,
   input logic             card_vpp_en,
   input logic             card_io_en,
   input logic             card_clk_en,
   input logic             card_rst,
   input logic [LVL_W-1:0] vpp_level,
   input logic             fault_irq_n,
   input logic [2:0]       mode
);

   // R11
   vpp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_vpp_en |-> card_vcc_en);

   // R11
   clk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_clk_en |-> (card_io_en && card_vpp_en));

   // R6
   level_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_level != '0) |-> (mode == M_WRITE));

   // R5
   rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |-> card_clk_en);

   // R10
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_FAULT && !cmd_vcc_n) |=> (mode == M_FAULT));

   // R9
   irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_irq_n |-> (mode == M_DEACT || mode == M_FAULT));

   // R1
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_IDLE) |-> !card_vcc_en);

   // R4
   read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_clk_en) |-> (mode == M_READ));

endmodule

bind card_session_seq cs_seq_chk #(.LVL_W(LVL_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_vcc_n   (cmd_vcc_n),
   .card_vcc_en (card_vcc_en),
   .card_vpp_en (card_vpp_en),
   .card_io_en  (card_io_en),
   .card_clk_en (card_clk_en),
   .card_rst    (card_rst),
   .vpp_level   (vpp_level),
   .fault_irq_n (fault_irq_n),
   .mode        (mode)
);

// File: tb/test_card_session_seq.sv
module test_card_session_seq;

   localparam int CLK_PERIOD = 10;
   localparam int TD  = 4;
   localparam int GA  = 16;
   localparam int GB  = 64;
   localparam int GD  = 48;
   localparam int EXP_A   = GA * TD + 1;
   localparam int EXP_B   = GB * TD + 1;
   localparam int EXP_D   = GD * TD + 1;
   localparam int EXP_END = TD + 1;

   localparam int M_IDLE = 0, M_ACT = 1, M_READ = 2, M_WRITE = 3, M_DEACT = 4, M_FAULT = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_vcc_n, host_io, pres_n, pres_h;
   logic       vcc_ocp, vpp_ocp, over_temp, host_sup_ok, main_sup_ok;
   logic [2:0] prog_sel_n;
   logic       rst_req;
   logic       card_vcc_en, card_vpp_en, card_io_en, card_clk_en, card_rst;
   logic [1:0] vpp_level;
   logic       card_det, fault_irq_n;
   logic [2:0] mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   card_session_seq #(
      .TICK_DIV   (TD),
      .GAP_VCC_IO (GA),
      .GAP_IO_CLK (GB),
      .GAP_DOWN   (GD),
      .N_LEVELS   (3)
   ) i_card_session_seq (
      .clk (clk), .rst_n (rst_n), .cmd_vcc_n (cmd_vcc_n), .host_io (host_io),
      .pres_n (pres_n), .pres_h (pres_h), .vcc_ocp (vcc_ocp), .vpp_ocp (vpp_ocp),
      .over_temp (over_temp), .host_sup_ok (host_sup_ok), .main_sup_ok (main_sup_ok),
      .prog_sel_n (prog_sel_n), .rst_req (rst_req), .card_vcc_en (card_vcc_en),
      .card_vpp_en (card_vpp_en), .card_io_en (card_io_en), .card_clk_en (card_clk_en),
      .card_rst (card_rst), .vpp_level (vpp_level), .card_det (card_det),
      .fault_irq_n (fault_irq_n), .mode (mode)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_near(input string req, input int act, input int exp, input int tol);
      checks++;
      if (act < exp - tol || act > exp + tol) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_level(input logic [2:0] s);
      if (!s[2]) return 3;
      if (!s[1]) return 2;
      if (!s[0]) return 1;
      return 0;
   endfunction

   function automatic logic get_sig(input int s);
      case (s)
         0: return card_vcc_en;
         1: return card_vpp_en;
         2: return card_clk_en;
         default: return fault_irq_n;
      endcase
   endfunction

   task automatic wait_sig(input int s, input logic v, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (get_sig(s) !== v && n < 5000);
   endtask

   task automatic wait_mode(input int m, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (int'(mode) != m && n < 5000);
   endtask

   task automatic idle_inputs();
      cmd_vcc_n = 1'b1; host_io = 1'b1; pres_n = 1'b0; pres_h = 1'b1;
      vcc_ocp = 1'b0; vpp_ocp = 1'b0; over_temp = 1'b0;
      host_sup_ok = 1'b1; main_sup_ok = 1'b1; prog_sel_n = 3'b111; rst_req = 1'b0;
   endtask

   task automatic set_fault(input int k, input logic v);
      case (k)
         0: vcc_ocp = v;
         1: vpp_ocp = v;
         2: over_temp = v;
         3: host_sup_ok = !v;
         4: main_sup_ok = !v;
         default: pres_h = !v;
      endcase
   endtask

   task automatic activate();
      int n;
      cmd_vcc_n = 1'b0;
      wait_sig(0, 1'b1, n);
      check("R4 supply rises one clock after command", n, 1);
      check("R4 programming supply off while only card supply is on", card_vpp_en, 0);
      check("R5 reset blocked before clock enable", card_rst, 0);
      check("R4 mode activation", mode, M_ACT);
      wait_sig(1, 1'b1, n);
      check_near("R4 gap supply to lines", n, EXP_A, 1);
      check("R4 io enabled with programming supply", card_io_en, 1);
      check("R4 clock still off", card_clk_en, 0);
      wait_sig(2, 1'b1, n);
      check_near("R4 gap lines to clock", n, EXP_B, 1);
      check("R4 read mode after activation", mode, M_READ);
   endtask

   task automatic deactivate();
      int n;
      cmd_vcc_n = 1'b1;
      wait_sig(2, 1'b0, n);
      check("R8 clock cut one clock after release", n, 1);
      check("R8 reset cut", card_rst, 0);
      check("R8 programming supply still on", card_vpp_en, 1);
      check("R8 level normal during shutdown", vpp_level, 0);
      check("R8 mode deactivation", mode, M_DEACT);
      wait_sig(1, 1'b0, n);
      check_near("R8 gap to lines off", n, EXP_D, 1);
      check("R8 io off with programming supply", card_io_en, 0);
      check("R8 card supply still on", card_vcc_en, 1);
      wait_sig(0, 1'b0, n);
      check_near("R8 gap to supply off", n, EXP_D, 1);
      wait_mode(M_IDLE, n);
      check_near("R8 idle one tick after supply off", n, EXP_END, 1);
      check("R8 no interrupt on normal end", fault_irq_n, 1);
   endtask

   task automatic sel_step(input logic [2:0] s);
      prog_sel_n = s;
      @(negedge clk);
      @(negedge clk);
      check("R6 level for select pattern", vpp_level, exp_level(s));
      check("R6 mode for select pattern", mode, (s != 3'b111) ? M_WRITE : M_READ);
   endtask

   task automatic fault_session(input int k, input bit same_cycle);
      int n;
      activate();
      set_fault(k, 1'b1);
      if (same_cycle) begin
         vcc_ocp = 1'b1;
         cmd_vcc_n = 1'b1;
      end
      @(negedge clk);
      check("R9 shutdown after fault", mode, M_DEACT);
      check("R9 interrupt low after fault", fault_irq_n, 0);
      check("R9 clock cut on fault", card_clk_en, 0);
      set_fault(k, 1'b0);
      vcc_ocp = 1'b0;
      wait_mode(M_FAULT, n);
      check_near("R9 full shutdown before fault mode", n, 2 * EXP_D + EXP_END, 2);
      check("R10 interrupt held in fault mode", fault_irq_n, 0);
      check("R10 supply off in fault mode", card_vcc_en, 0);
      if (!same_cycle) begin
         repeat (20) @(negedge clk);
         check("R10 fault mode held while command low", mode, M_FAULT);
         check("R10 interrupt still low", fault_irq_n, 0);
         cmd_vcc_n = 1'b1;
      end
      @(negedge clk);
      check("R10 idle after command high", mode, M_IDLE);
      check("R10 interrupt released", fault_irq_n, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 mode idle after reset", mode, M_IDLE);
      check("R1 enables off", {card_vcc_en, card_vpp_en, card_io_en, card_clk_en, card_rst}, 0);
      check("R1 level normal", vpp_level, 0);
      check("R1 interrupt high", fault_irq_n, 1);

      // R2 presence combinations
      for (int i = 0; i < 4; i++) begin
         pres_n = i[0]; pres_h = i[1];
         #1;
         check("R2 card detect", card_det, (i == 2) ? 1 : 0);
      end
      pres_n = 1'b0; pres_h = 1'b1;
      @(negedge clk);

      // R3 blocking conditions
      for (int k = 0; k < 4; k++) begin
         case (k)
            0: host_io = 1'b0;
            1: main_sup_ok = 1'b0;
            2: host_sup_ok = 1'b0;
            default: pres_h = 1'b0;
         endcase
         cmd_vcc_n = 1'b0;
         repeat (30) @(negedge clk);
         check("R3 start blocked mode", mode, M_IDLE);
         check("R3 start blocked supply", card_vcc_en, 0);
         cmd_vcc_n = 1'b1;
         @(negedge clk);
         idle_inputs();
         @(negedge clk);
      end

      // R7 selects in idle
      prog_sel_n = 3'b000;
      repeat (5) @(negedge clk);
      check("R7 level ignored in idle", vpp_level, 0);
      check("R7 mode unchanged in idle", mode, M_IDLE);
      prog_sel_n = 3'b111;

      // R4 R5 R6 directed session
      rst_req = 1'b1;
      activate();
      @(negedge clk);
      check("R5 reset passes once clock enabled", card_rst, 1);
      rst_req = 1'b0;
      @(negedge clk);
      check("R5 reset follows request low", card_rst, 0);
      sel_step(3'b110);
      sel_step(3'b101);
      sel_step(3'b000);
      sel_step(3'b011);
      sel_step(3'b111);
      for (int i = 0; i < 12; i++) sel_step(3'($urandom_range(0, 7)));
      prog_sel_n = 3'b001;
      @(negedge clk);
      @(negedge clk);
      deactivate();
      prog_sel_n = 3'b111;

      // R9 R10 every fault source
      for (int k = 0; k < 6; k++) fault_session(k, 1'b0);

      // fault and command release in the same cycle
      fault_session(1, 1'b1);

      // R7 selects in fault-held mode
      activate();
      vpp_ocp = 1'b1;
      @(negedge clk);
      vpp_ocp = 1'b0;
      prog_sel_n = 3'b000;
      repeat (30) @(negedge clk);
      check("R7 level ignored during shutdown", vpp_level, 0);
      check("R7 mode unchanged by select", mode, M_DEACT);
      prog_sel_n = 3'b111;
      cmd_vcc_n = 1'b1;
      begin
         int n;
         wait_mode(M_IDLE, n);
      end
      check("R10 fault ends in idle", fault_irq_n, 1);

      // random sessions
      for (int it = 0; it < 6; it++) begin
         if ($urandom_range(0, 1) == 1) begin
            fault_session(int'($urandom_range(0, 5)), 1'b0);
         end else begin
            activate();
            for (int j = 0; j < 3; j++) sel_step(3'($urandom_range(0, 7)));
            deactivate();
            prog_sel_n = 3'b111;
         end
         repeat (3) @(negedge clk);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule